// File: doc/BRIEF.md
# Baud Divisor Calculator

This block turns an oscillator frequency and a requested serial bit rate into the 16-bit divisor that a UART clock generator uses, where the generator ticks sixteen times per bit. Both inputs are 32-bit integers in hertz and bits per second. The block avoids a wide divider. It first prescales the frequency by sixteen and keeps a 24-bit working value. It then halves the frequency and the rate together until the frequency fits in 16 bits. A small sequential restoring divider finishes the job, and its quotient is truncated.

The caller waits for `ready_o`, places both operands on the inputs and pulses `start_i` for one cycle. Some cycles later `done_o` pulses for a single cycle. At that pulse `divisor_o` and `err_o` carry the result, and both hold it until the next result. A start request that arrives while the block is busy has no effect.

Top module: `baud_div_calc`

## Requirements
- R1: The frequency is prescaled by a right shift of four places, so bits 3:0 of `osc_hz_i` never change the result. For example, 16015 Hz and 16000 Hz both give 1000.
- R2: After prescaling only 24 bits are kept, so bits 31:28 of `osc_hz_i` never change the result.
- R3: While bits 23:16 of the working frequency are nonzero, the frequency and the rate are both shifted right by one place. Both shifts happen in the same cycle, one shift per cycle.
- R4: When the normalised rate is between 1 and 65535, `divisor_o` is the truncated quotient of the normalised frequency divided by the normalised rate. This includes 0, when the rate exceeds the frequency, and 65535.
- R5: When the normalised rate is zero, `err_o` is 1 and `divisor_o` is 16'hFFFF. This applies to a zero input rate and also to a rate that shifts down to zero.
- R6: When the normalised rate is 65536 or more, `divisor_o` is 0 and `err_o` is 0.
- R7: Normalisation takes at most 8 shifts. `done_o` is high no later than the 27th clock edge after the edge that accepts `start_i`.
- R8: `start_i` is ignored whenever `ready_o` is low, including the cycle in which `done_o` is high. Such a request produces no further result and does not change the result in flight.
- R9: `ready_o` is high only while idle. `done_o` is high for exactly one cycle per accepted start. `divisor_o` and `err_o` hold their value until the next result.
- R10: After reset `ready_o` is 1, `done_o` is 0, `divisor_o` is 0 and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a computation; accepted only while ready_o is high |
| osc_hz_i | input | 32 | Oscillator frequency in Hz |
| baud_i | input | 32 | Target bit rate |
| ready_o | output | 1 | Idle and able to accept start_i |
| done_o | output | 1 | One-cycle pulse when a new result is presented |
| divisor_o | output | 16 | Computed divisor, held between results |
| err_o | output | 1 | Normalised rate was zero; divisor forced to all ones |

## Verification
Two events can meet in the same cycle: the completion pulse of one computation and a new start request. In that cycle the block is not idle, so the request must be dropped. The bench provokes this by raising `start_i`, with fresh operands, in the exact cycle it sees `done_o`. It then waits well beyond the longest latency and judges the outcome by two things: no further completion pulse may appear, and the number of completion pulses must still equal the number of accepted starts. The same judgement covers a start that is raised in the middle of a computation, and in that case the pending result must also match the first operands.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_NORM = 2'd1,
      ST_DIV  = 2'd2,
      ST_FIN  = 2'd3
   } calc_state_e;

endpackage

// File: rtl/baud_div_norm.sv
module baud_div_norm #(
   parameter int OSC_W  = 32,
   parameter int BAUD_W = 32,
   parameter int PRE_SH = 4,
   parameter int WORK_W = 24,
   parameter int QUOT_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              shift_i,
   input  logic [OSC_W-1:0]  osc_i,
   input  logic [BAUD_W-1:0] baud_i,
   output logic              fits_o,
   output logic [QUOT_W-1:0] num_o,
   output logic [BAUD_W-1:0] den_o
);

   localparam int NORM_MAX = WORK_W - QUOT_W;
   localparam int CNT_W    = $clog2(NORM_MAX + 1);

   generate
      if (WORK_W <= QUOT_W) begin : g_bad_work
         $error("baud_div_norm: WORK_W must exceed QUOT_W");
      end
      if (WORK_W + PRE_SH > OSC_W) begin : g_bad_pre
         $error("baud_div_norm: WORK_W + PRE_SH must not exceed OSC_W");
      end
   endgenerate

   logic [OSC_W-1:0]  pre_scaled;
   logic [WORK_W-1:0] frq_q;
   logic [BAUD_W-1:0] bd_q;
   logic [CNT_W-1:0]  sh_cnt_q;

   assign pre_scaled = osc_i >> PRE_SH;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         frq_q    <= '0;
         bd_q     <= '0;
         sh_cnt_q <= '0;
      end else if (load_i) begin
         frq_q    <= pre_scaled[WORK_W-1:0];
         bd_q     <= baud_i;
         sh_cnt_q <= '0;
      end else if (shift_i) begin
         frq_q    <= frq_q >> 1;
         bd_q     <= bd_q >> 1;
         sh_cnt_q <= sh_cnt_q + 1'b1;
      end
   end

   assign fits_o = ~|frq_q[WORK_W-1:QUOT_W];
   assign num_o  = frq_q[QUOT_W-1:0];
   assign den_o  = bd_q;

   // R3: frequency and rate move down together, one place per shift
   a_r3_joint_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shift_i && !load_i) |=> (frq_q == ($past(frq_q) >> 1)) && (bd_q == ($past(bd_q) >> 1)));

   // R7: a shift is never requested once NORM_MAX shifts have been made
   a_r7_norm_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_i |-> (sh_cnt_q < CNT_W'(NORM_MAX)));

endmodule

// File: rtl/baud_div_divider.sv
module baud_div_divider #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         start_i,
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] den_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] quot_o
);

   localparam int CNT_W = $clog2(W + 1);

   generate
      if (W < 2) begin : g_bad_w
         $error("baud_div_divider: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]     rem_q;
   logic [W-1:0]     quo_q;
   logic [W-1:0]     den_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   logic [W:0]       rem_sh;
   logic [W:0]       diff;
   logic             take;

   assign rem_sh = {rem_q, quo_q[W-1]};
   assign diff   = rem_sh - {1'b0, den_q};
   assign take   = (rem_sh >= {1'b0, den_q});

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rem_q  <= '0;
         quo_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            rem_q <= '0;
            quo_q <= num_i;
            den_q <= den_i;
            cnt_q <= CNT_W'(W);
         end else if (cnt_q != '0) begin
            rem_q  <= take ? diff[W-1:0] : rem_sh[W-1:0];
            quo_q  <= {quo_q[W-2:0], take};
            cnt_q  <= cnt_q - 1'b1;
            done_q <= (cnt_q == CNT_W'(1));
         end
      end
   end

   assign busy_o = (cnt_q != '0);
   assign done_o = done_q;
   assign quot_o = quo_q;

   // R4: at completion the remainder left over is smaller than the divisor
   a_r4_rem_below_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (rem_q < den_q));

endmodule

// File: rtl/baud_div_calc.sv
module baud_div_calc
   import baud_div_pkg::*;
#(
   parameter int OSC_W  = 32,
   parameter int BAUD_W = 32,
   parameter int PRE_SH = 4,
   parameter int WORK_W = 24,
   parameter int QUOT_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [OSC_W-1:0]  osc_hz_i,
   input  logic [BAUD_W-1:0] baud_i,
   output logic              ready_o,
   output logic              done_o,
   output logic [QUOT_W-1:0] divisor_o,
   output logic              err_o
);

   generate
      if (BAUD_W < QUOT_W) begin : g_bad_baud
         $error("baud_div_calc: BAUD_W must be at least QUOT_W");
      end
   endgenerate

   calc_state_e       state_q;
   logic              load, shift, fits;
   logic [QUOT_W-1:0] num;
   logic [BAUD_W-1:0] den;
   logic              den_zero, den_big;
   logic              div_start, div_busy, div_done;
   logic [QUOT_W-1:0] quot;
   logic [QUOT_W-1:0] div_q;
   logic              err_q;

   baud_div_norm #(
      .OSC_W (OSC_W),
      .BAUD_W(BAUD_W),
      .PRE_SH(PRE_SH),
      .WORK_W(WORK_W),
      .QUOT_W(QUOT_W)
   ) norm_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .shift_i(shift),
      .osc_i  (osc_hz_i),
      .baud_i (baud_i),
      .fits_o (fits),
      .num_o  (num),
      .den_o  (den)
   );

   generate
      if (BAUD_W > QUOT_W) begin : g_den_wide
         assign den_big = |den[BAUD_W-1:QUOT_W];
      end else begin : g_den_narrow
         assign den_big = 1'b0;
      end
   endgenerate

   assign den_zero  = (den == '0);
   assign load      = (state_q == ST_IDLE) && start_i;
   assign shift     = (state_q == ST_NORM) && !fits;
   assign div_start = (state_q == ST_NORM) && fits && !den_zero && !den_big;

   baud_div_divider #(
      .W(QUOT_W)
   ) div_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(div_start),
      .num_i  (num),
      .den_i  (den[QUOT_W-1:0]),
      .busy_o (div_busy),
      .done_o (div_done),
      .quot_o (quot)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         div_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) state_q <= ST_NORM;
            ST_NORM: begin
               if (fits) begin
                  if (den_zero) begin
                     div_q   <= '1;
                     err_q   <= 1'b1;
                     state_q <= ST_FIN;
                  end else if (den_big) begin
                     div_q   <= '0;
                     err_q   <= 1'b0;
                     state_q <= ST_FIN;
                  end else begin
                     state_q <= ST_DIV;
                  end
               end
            end
            ST_DIV: begin
               if (div_done) begin
                  div_q   <= quot;
                  err_q   <= 1'b0;
                  state_q <= ST_FIN;
               end
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ready_o   = (state_q == ST_IDLE);
   assign done_o    = (state_q == ST_FIN);
   assign divisor_o = div_q;
   assign err_o     = err_q;

   // R9: the completion pulse lasts one cycle and is followed by idle
   a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> (!done_o && ready_o));

   // R8: a start while not ready leaves the block not idle in the next cycle unless it finishes
   a_r8_busy_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ready_o && !done_o && start_i) |=> !ready_o);

   // R6: an oversized normalised rate yields a zero divisor without error
   a_r6_big_rate_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_NORM && fits && den_big) |=> (divisor_o == '0 && !err_o && done_o));

   // R5: a zero normalised rate yields the error flag and an all-ones divisor
   a_r5_zero_rate_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_NORM && fits && den_zero) |=> (err_o && divisor_o == '1));

   // R4: the divider only runs while the block is in its divide phase
   a_r4_div_in_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_busy |-> (state_q == ST_DIV));

endmodule

// File: tb/baud_div_calc_tb_top.sv
module baud_div_calc_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int MAX_LAT    = 27;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] osc = '0;
   logic [31:0] baud = '0;
   logic        ready_o, done_o, err_o;
   logic [15:0] divisor_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   baud_div_calc dut_i (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .start_i  (start),
      .osc_hz_i (osc),
      .baud_i   (baud),
      .ready_o  (ready_o),
      .done_o   (done_o),
      .divisor_o(divisor_o),
      .err_o    (err_o)
   );

   typedef struct {
      logic [15:0] dv;
      logic        er;
      string       req;
   } exp_item_t;

   exp_item_t sb[$];
   int n_run = 0;
   int n_fail = 0;
   int n_done = 0;
   int n_accepted = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic void model(input logic [31:0] o, input logic [31:0] b,
                                 output logic [15:0] dv, output logic er);
      logic [23:0] f;
      logic [31:0] d;
      f = o[27:4];
      d = b;
      while (f[23:16] != 8'd0) begin
         f = f >> 1;
         d = d >> 1;
      end
      if (d == 0) begin
         dv = 16'hFFFF; er = 1'b1;
      end else if (d > 32'hFFFF) begin
         dv = 16'h0; er = 1'b0;
      end else begin
         dv = 16'(32'(f[15:0]) / d); er = 1'b0;
      end
   endfunction

   // monitor: pop and compare on every completion pulse
   always @(negedge clk) begin
      exp_item_t e;
      if (rst_n && done_o) begin
         n_done++;
         if (sb.size() == 0) begin
            check(1'b0, "R8", "unexpected completion", 1, 0);
         end else begin
            e = sb.pop_front();
            check(divisor_o == e.dv, e.req, "divisor", divisor_o, e.dv);
            check(err_o == e.er, e.req, "error flag", err_o, e.er);
         end
      end
   end

   task automatic launch(input logic [31:0] o, input logic [31:0] b, input string req);
      exp_item_t e;
      while (!ready_o) @(negedge clk);
      osc = o;
      baud = b;
      start = 1'b1;
      model(o, b, e.dv, e.er);
      e.req = req;
      sb.push_back(e);
      n_accepted++;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output int lat);
      lat = 1;
      while (!done_o) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic run(input logic [31:0] o, input logic [31:0] b, input string req);
      int lat;
      launch(o, b, req);
      wait_done(lat);
      check(lat <= MAX_LAT, "R7", "latency", lat, MAX_LAT);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int lat;
      logic [15:0] held;
      logic [31:0] lo, lb;
      repeat (3) @(negedge clk);
      // R10: reset values
      check(ready_o == 1'b1, "R10", "ready in reset", ready_o, 1);
      check(done_o == 1'b0, "R10", "done in reset", done_o, 0);
      check(divisor_o == 16'h0, "R10", "divisor in reset", divisor_o, 0);
      check(err_o == 1'b0, "R10", "err in reset", err_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      run(32'd1843200, 32'd9600, "R3");           // one joint shift -> 12
      run(32'd18432000, 32'd115200, "R3");        // five shifts -> 10
      run(32'hF000_0000 | 32'd1843200, 32'd9600, "R2");
      run(32'd16000, 32'd7, "R4");                // 1000/7 -> 142
      run(32'd16015, 32'd7, "R1");                // low nibble dropped -> 142
      run(32'd16000, 32'd1000, "R4");             // equal -> 1
      run(32'd80, 32'd9, "R4");                   // 5/9 -> 0
      run(32'h000F_FFF0, 32'd1, "R4");            // 65535 without error
      run(32'd1843200, 32'd0, "R5");              // zero rate
      run(32'h0FFF_FFF0, 32'd200, "R5");          // rate shifts to zero
      run(32'd160, 32'h0002_0000, "R6");          // oversized rate -> 0
      run(32'h0FFF_FFF0, 32'h100, "R7");          // eight shifts -> 65535

      // R9: result held after the pulse, ready only while idle
      launch(32'd3686400, 32'd19200, "R9");
      repeat (3) @(negedge clk);
      check(ready_o == 1'b0, "R9", "ready while busy", ready_o, 0);
      wait_done(lat);
      held = divisor_o;
      repeat (3) @(negedge clk);
      check(divisor_o == held, "R9", "divisor held", divisor_o, held);
      check(done_o == 1'b0, "R9", "done single cycle", done_o, 0);
      check(ready_o == 1'b1, "R9", "ready when idle", ready_o, 1);

      // R8: start during a computation, then start in the completion cycle
      launch(32'd7372800, 32'd38400, "R8");
      repeat (4) @(negedge clk);
      osc = 32'd1000;
      baud = 32'd3;
      start = 1'b1;
      repeat (2) @(negedge clk);
      start = 1'b0;
      wait_done(lat);
      osc = 32'd5000;
      baud = 32'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      check(n_done == n_accepted, "R8", "completion count", n_done, n_accepted);
      check(ready_o == 1'b1, "R8", "idle after ignored start", ready_o, 1);

      // R4: a spread of generated operands
      lo = 32'h1234_5678;
      lb = 32'h0000_4B00;
      for (int i = 0; i < 20; i++) begin
         lo = lo * 32'd1664525 + 32'd1013904223;
         lb = lb * 32'd22695477 + 32'd1;
         run(lo, lb >> (i % 24), "R4");
      end

      check(sb.size() == 0, "R9", "pending results", sb.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule